// File: doc/BRIEF.md
# Loopback-Capable Word Serializer

This block turns a stream of 10-bit code words into a serial bit stream at ten times the word rate. It runs entirely on the bit clock. A free-running divide-by-ten counter marks one bit period in every ten with a byte strobe. On the rising edge that ends a strobe period, the block samples the parallel word and loads it into a shift register. The word then leaves one bit per bit clock, starting with bit 0. Successive words follow each other with no gap.

A loopback enable chooses where the stream goes. With loopback off, the stream drives the external serial output, and the receive-side selector passes the external serial input through. With loopback on, the external output is held at logic 1. The stream still runs on the internal wrap output, and the receive-side selector takes the wrapped stream instead of the line input. The wrap path therefore allows a transmit-to-receive test that never touches the medium.

Top module: `ser_wrap`

## Requirements
- R1: While rst_n is low, ser_out and wrap_out are 1. The bit counter is cleared, so byte_stb stays low for the first nine rising edges after rst_n goes high and is high after the ninth.
- R2: After reset, byte_stb is high in exactly one bit period out of every ten and is never high in two consecutive periods.
- R3: word_in is sampled only at the rising edge that ends a byte_stb-high period. Values on word_in in any other period have no effect on the serial stream.
- R4: Bit k of a word sampled at edge E appears on wrap_out after edge E+1+k, for k = 0 to 9. Bit 0 (the least significant bit) goes first, and the latency from capture to the first bit is one bit clock.
- R5: Words are sent back to back: bit 9 of one word is followed directly by bit 0 of the next word.
- R6: Before the first word is sampled after reset, wrap_out carries logic 1.
- R7: With loop_en low, ser_out equals wrap_out in every bit period.
- R8: With loop_en high, ser_out is constant 1, and the stream continues on wrap_out without losing its position.
- R9: The receive-side selector output rx_ser equals line_rx_in when loop_en is low. It equals wrap_out when loop_en is high, and line_rx_in is then ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Synchronous reset, active low |
| word_in | input | 10 | Parallel code word, bit 0 sent first |
| loop_en | input | 1 | 1 routes the stream to the internal wrap path only |
| line_rx_in | input | 1 | External serial input for the receive side |
| byte_stb | output | 1 | High in the bit period whose closing edge samples word_in |
| ser_out | output | 1 | External serial output, held at 1 in loopback or reset |
| wrap_out | output | 1 | Internal wrapped serial stream |
| rx_ser | output | 1 | Serial source selected for the receiver |

## Verification
A bit counter that has drifted or was not cleared shows on byte_stb within ten bit clocks. It also rotates every later word on wrap_out, which corrupts the next received bit. An error in the shift order or the fill shows on wrap_out within one word time of the capture edge. A wrong selector setting shows on ser_out or rx_ser in the same bit period that loop_en changes. The bench compares every bit period against a record of the captured words, indexed by the number of edges since reset, under random and directed words and loopback patterns.

// File: rtl/ser_wrap.sv
module ser_wrap #(
  parameter int WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] word_in,
  input  logic              loop_en,
  input  logic              line_rx_in,
  output logic              byte_stb,
  output logic              ser_out,
  output logic              wrap_out,
  output logic              rx_ser
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [CNT_W-1:0]  bit_cnt;
  logic [WORD_W-1:0] shreg;
  logic              tx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      shreg   <= '1;
      tx_q    <= 1'b1;
    end else begin
      tx_q <= shreg[0];
      if (bit_cnt == LAST) begin
        bit_cnt <= '0;
        shreg   <= word_in;
      end else begin
        bit_cnt <= bit_cnt + 1'b1;
        shreg   <= {1'b1, shreg[WORD_W-1:1]};
      end
    end
  end

  assign byte_stb = rst_n && (bit_cnt == LAST);
  assign wrap_out = !rst_n || tx_q;
  assign ser_out  = loop_en || wrap_out;
  assign rx_ser   = loop_en ? wrap_out : line_rx_in;
endmodule

module ser_wrap_chk #(
  parameter int WORD_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic [WORD_W-1:0] word_in,
  input logic              loop_en,
  input logic              line_rx_in,
  input logic              byte_stb,
  input logic              ser_out,
  input logic              wrap_out,
  input logic              rx_ser
);
  int ck_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) ck_cnt <= 0;
    else        ck_cnt <= (ck_cnt == WORD_W - 1) ? 0 : ck_cnt + 1;
  end

  always @(posedge clk) begin
    if (!rst_n) assert_reset_idle_R1: assert (ser_out && wrap_out);
  end

  assert_stb_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
    byte_stb == (ck_cnt == WORD_W - 1));
  assert_stb_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    byte_stb |=> !byte_stb);
  assert_lsb_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    byte_stb |=> ##1 (wrap_out == $past(word_in[0], 2)));
  assert_line_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !loop_en |-> (ser_out == wrap_out));
  assert_loop_static_R8: assert property (@(posedge clk) disable iff (!rst_n)
    loop_en |-> ser_out);
  assert_rx_select_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ser == (loop_en ? wrap_out : line_rx_in));
endmodule

bind ser_wrap ser_wrap_chk #(.WORD_W(WORD_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .word_in(word_in), .loop_en(loop_en),
  .line_rx_in(line_rx_in), .byte_stb(byte_stb), .ser_out(ser_out),
  .wrap_out(wrap_out), .rx_ser(rx_ser)
);

// File: tb/ser_wrap_tb.sv
`timescale 1ns/1ps
module ser_wrap_tb_top;
  localparam int W = 10;
  localparam int NCYC = 4000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] word_in = '0;
  logic loop_en = 1'b0;
  logic line_rx_in = 1'b0;
  logic byte_stb, ser_out, wrap_out, rx_ser;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [W-1:0] cap [0:NCYC/W + 2];
  logic [W-1:0] dir_words [0:5];

  always #2 clk = ~clk;

  ser_wrap #(.WORD_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .word_in(word_in), .loop_en(loop_en),
    .line_rx_in(line_rx_in), .byte_stb(byte_stb), .ser_out(ser_out),
    .wrap_out(wrap_out), .rx_ser(rx_ser)
  );

  task automatic check(input bit ok, input string req, input int got, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s got=%0d expected=%0d at %0t", req, got, exp, $time);
    end
  endtask

  function automatic logic exp_bit(input int m);
    int t;
    t = m - 1;
    return cap[t / W][t % W];
  endfunction

  initial begin
    int unsigned sd;
    int m;
    logic e;
    sd = $urandom(32'd4242);
    dir_words[0] = 10'h000; dir_words[1] = 10'h3FF; dir_words[2] = 10'h001;
    dir_words[3] = 10'h200; dir_words[4] = 10'h155; dir_words[5] = 10'h2AA;
    cap[0] = '1;
    m = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(ser_out == 1'b1, "R1 ser_out in reset", int'(ser_out), 1);
    check(wrap_out == 1'b1, "R1 wrap_out in reset", int'(wrap_out), 1);
    check(byte_stb == 1'b0, "R1 byte_stb in reset", int'(byte_stb), 0);
    rst_n = 1'b1;
    word_in = $urandom();
    line_rx_in = $urandom();
    for (int c = 0; c < NCYC; c++) begin
      @(posedge clk);
      m++;
      if (m % W == 0) cap[m / W] = word_in;
      @(negedge clk);
      e = exp_bit(m);
      check(byte_stb == (m % W == W - 1), (m < W) ? "R1 first strobe" : "R2 strobe period",
            int'(byte_stb), int'(m % W == W - 1));
      check(wrap_out == e, (m <= W) ? "R6 idle fill" : ((m - 1) % W == 0) ? "R5 word boundary" : "R4 bit order",
            int'(wrap_out), int'(e));
      if (loop_en) begin
        check(ser_out == 1'b1, "R8 ser_out static", int'(ser_out), 1);
        check(rx_ser == e, "R9 rx takes wrap", int'(rx_ser), int'(e));
      end else begin
        check(ser_out == e, "R7 ser_out stream", int'(ser_out), int'(e));
        check(rx_ser == line_rx_in, "R9 rx takes line", int'(rx_ser), int'(line_rx_in));
      end
      // R3: word_in changes every period; only strobe-edge values may appear on the stream
      if ((m + 1) % W == 0 && (m + 1) / W - 1 < 6) word_in = dir_words[(m + 1) / W - 1];
      else word_in = W'($urandom());
      line_rx_in = $urandom();
      if (m < 600) loop_en = 1'b0;
      else if (m < 1200) loop_en = 1'b1;
      else if ($urandom() % 8 == 0) loop_en = ~loop_en;
    end
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(4 * (NCYC + 500));
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog got=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule